// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash interface. It decides whether a program or erase that is already under way inside the memory has finished. A one-cycle start pulse begins the check. The poller then issues status reads, which may target any address, so the block has no address output. It takes the status byte returned by each read and compares the chosen toggle bit between consecutive reads.

If the toggle bit holds steady across a pair of reads, the operation is over and the poller pulses `done`. If the bit is still changing, the poller looks at the timeout flag (bit 5) of the newer byte. When that flag is low, it simply starts another pair of reads. When the flag is high, the poller takes one more pair of reads, because toggling may have stopped at the same moment the flag rose. A steady bit in that last pair still counts as success. A changing bit ends the check with a `fail` pulse.

A parameter selects bit 6 or bit 2 as the toggle bit. The read port is a plain request/acknowledge pair: data is taken on any cycle in which both `rd_req` and `rd_ack` are high.

Top module: `toggle_poll_top`

## Requirements
- R1: A synchronous reset, sampled at a rising clock edge, leaves `rd_req`, `done` and `fail` low and the poller idle.
- R2: A `start` pulse while idle raises `rd_req` on the next cycle. `rd_req` then stays high until the check ends, and each cycle with `rd_ack` high completes one read, so reads run back to back.
- R3: A check consists of two reads. If the toggle bit is equal in both, `done` is high for exactly the cycle after the second accepted read, and `rd_req` is low in that same cycle.
- R4: If the toggle bit differs between the two reads and bit 5 of the second (newer) byte is 0, the poller starts a new two-read check. Bit 5 of the older byte has no effect.
- R5: If the toggle bit differs and bit 5 of the newer byte is 1, the poller takes two more reads. If the toggle bit is equal in those two, it reports `done`.
- R6: If the toggle bit still differs in the confirming pair, `fail` is high for exactly the cycle after the fourth read of that sequence, and `rd_req` is low in that cycle.
- R7: Parameter `TOGGLE_SEL` (6 or 2, default 6) names the toggle bit. Bits other than the toggle bit and bit 5 never change the outcome or the number of reads.
- R8: A `start` pulse that arrives while a check is running is ignored: the outcome and the read count are the same as without it.
- R9: `done` and `fail` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a completion check |
| rd_req | output | 1 | Status read requested |
| rd_ack | input | 1 | Read completed; `rd_data` is valid |
| rd_data | input | 8 | Status byte returned by the read |
| done | output | 1 | One-cycle pulse: the operation has completed |
| fail | output | 1 | One-cycle pulse: the operation did not complete after the timeout flag |

## Verification
If the state machine goes wrong internally, the first sign at the ports is the number of reads accepted before the terminating pulse, or the kind of pulse it gives. A stored reference bit that is wrong, or a branch that is wrong, changes the outcome within the same two-read pair. A bad timeout-flag decision adds or removes exactly two reads. A bad end transition shows up in the cycle right after the last acknowledge, either as `rd_req` still high or as a pulse that lasts too long. For that reason the bench counts the accepted reads and the pulses for every scenario, and it checks the width of each pulse.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAIR_A,
        ST_PAIR_B,
        ST_CONF_A,
        ST_CONF_B
    } tbp_state_e;

    typedef struct packed {
        tbp_state_e state;
        logic       ref_bit;
        logic       done;
        logic       fail;
    } tbp_regs_t;

endpackage

// File: rtl/tbp_bit_pick.sv
module tbp_bit_pick #(
    parameter int DATA_W  = 8,
    parameter int TOG_IDX = 6,
    parameter int ERR_IDX = 5
) (
    input  logic [DATA_W-1:0] data,
    output logic              tog,
    output logic              err
);
    generate
        if (TOG_IDX < DATA_W) begin : g_tog
            assign tog = data[TOG_IDX];
        end else begin : g_tog_none
            assign tog = 1'b0;
        end
        if (ERR_IDX < DATA_W) begin : g_err
            assign err = data[ERR_IDX];
        end else begin : g_err_none
            assign err = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/tbp_ctrl.sv
module tbp_ctrl
    import tbp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rd_ack,
    input  logic tog,
    input  logic err,
    output logic rd_req,
    output logic done,
    output logic fail
);
    tbp_regs_t r_q, r_d;
    logic      accept;

    assign rd_req = (r_q.state != ST_IDLE);
    assign accept = rd_req && rd_ack;
    assign done   = r_q.done;
    assign fail   = r_q.fail;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) r_d.state = ST_PAIR_A;
            end
            ST_PAIR_A: begin
                if (accept) begin
                    r_d.ref_bit = tog;
                    r_d.state   = ST_PAIR_B;
                end
            end
            ST_PAIR_B: begin
                if (accept) begin
                    if (tog == r_q.ref_bit) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else if (err) begin
                        r_d.state = ST_CONF_A;
                    end else begin
                        r_d.state = ST_PAIR_A;
                    end
                end
            end
            ST_CONF_A: begin
                if (accept) begin
                    r_d.ref_bit = tog;
                    r_d.state   = ST_CONF_B;
                end
            end
            ST_CONF_B: begin
                if (accept) begin
                    if (tog == r_q.ref_bit) r_d.done = 1'b1;
                    else                    r_d.fail = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state   <= ST_IDLE;
            r_q.ref_bit <= 1'b0;
            r_q.done    <= 1'b0;
            r_q.fail    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_START_REQ:  assert property (@(posedge clk) disable iff (rst) (!rd_req && start) |=> rd_req); // R2
    AST_REQ_HOLD:   assert property (@(posedge clk) disable iff (rst) (rd_req && !rd_ack) |=> rd_req); // R2
    AST_END_ON_ACK: assert property (@(posedge clk) disable iff (rst) (done || fail) |-> $past(rd_req && rd_ack)); // R3
    AST_EXCL:       assert property (@(posedge clk) disable iff (rst) !(done && fail)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (rst) fail |=> !fail); // R6
endmodule

// File: rtl/toggle_poll_top.sv
module toggle_poll_top #(
    parameter int TOGGLE_SEL = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       rd_req,
    input  logic       rd_ack,
    input  logic [7:0] rd_data,
    output logic       done,
    output logic       fail
);
    localparam int DATA_W  = 8;
    localparam int ERR_IDX = 5;
    localparam int TOG_IDX = (TOGGLE_SEL == 2) ? 2 : 6;

    logic tog, err;

    tbp_bit_pick #(
        .DATA_W (DATA_W),
        .TOG_IDX(TOG_IDX),
        .ERR_IDX(ERR_IDX)
    ) u_pick (
        .data(rd_data),
        .tog (tog),
        .err (err)
    );

    tbp_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .rd_ack(rd_ack),
        .tog   (tog),
        .err   (err),
        .rd_req(rd_req),
        .done  (done),
        .fail  (fail)
    );
endmodule

// File: tb/tb_toggle_poll_top.sv
module tb_toggle_poll_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rd_req;
    logic       rd_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       done, fail;

    int errors = 0;
    int checks = 0;

    logic [7:0] script [0:15];
    int  idx = 0;
    int  n_reads = 0, n_done = 0, n_fail = 0, bad_width = 0;
    bit  gap_mode = 0, gap_ph = 0;
    logic done_prev = 0, fail_prev = 0;

    always #10 clk = ~clk;

    toggle_poll_top dut (
        .clk(clk), .rst(rst), .start(start), .rd_req(rd_req),
        .rd_ack(rd_ack), .rd_data(rd_data), .done(done), .fail(fail)
    );

    // responder: drive shortly after the rising edge
    always @(posedge clk) begin
        #2;
        gap_ph  = ~gap_ph;
        rd_ack  = rd_req && (!gap_mode || gap_ph);
        rd_data = script[idx[3:0]];
    end

    // monitor: sample at the falling edge
    always @(negedge clk) begin
        if (rd_req && rd_ack) begin idx++; n_reads++; end
        if (done) n_done++;
        if (fail) n_fail++;
        if ((done && done_prev) || (fail && fail_prev) || (done && fail)) bad_width++;
        if ((done || fail) && rd_req) bad_width++;
        done_prev = done;
        fail_prev = fail;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        idx = 0; n_reads = 0; n_done = 0; n_fail = 0; bad_width = 0;
    endtask

    task automatic run(input string req, input bit gap, input bit extra_start,
                       input int exp_reads, input int exp_done, input int exp_fail);
        int w;
        clear_counts();
        gap_mode = gap;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk({req, " rd_req after start (R2)"}, int'(rd_req), 1);
        if (extra_start) begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        w = 0;
        while (n_done == 0 && n_fail == 0 && w < 400) begin
            @(negedge clk); w++;
        end
        if (w >= 400) chk({req, " watchdog"}, 0, 1);
        repeat (4) @(negedge clk);
        chk({req, " reads"}, n_reads, exp_reads);
        chk({req, " done pulses"}, n_done, exp_done);
        chk({req, " fail pulses"}, n_fail, exp_fail);
        chk({req, " pulse shape (R9)"}, bad_width, 0);
        chk({req, " rd_req low after end"}, int'(rd_req), 0);
    endtask

    task automatic t_reset();
        chk("R1 rd_req", int'(rd_req), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 fail", int'(fail), 0);
    endtask

    task automatic t_steady();     // R3
        script[0] = 8'h40; script[1] = 8'h40;
        run("R3 steady", 0, 0, 2, 1, 0);
    endtask

    task automatic t_repeat();     // R4
        script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h00; script[3] = 8'h00;
        run("R4 repeat", 1, 0, 4, 1, 0);
    endtask

    task automatic t_old_flag();   // R4: bit 5 of older byte ignored
        script[0] = 8'h20; script[1] = 8'h40; script[2] = 8'h40; script[3] = 8'h40;
        run("R4 older flag", 0, 0, 4, 1, 0);
    endtask

    task automatic t_confirm_ok(); // R5
        script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h20; script[3] = 8'h20;
        run("R5 confirm ok", 0, 0, 4, 1, 0);
    endtask

    task automatic t_confirm_bad(); // R6
        script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h20; script[3] = 8'h60;
        run("R6 confirm fail", 1, 0, 4, 0, 1);
    endtask

    task automatic t_other_bits(); // R7: bit 2 and others ignored when bit 6 selected
        script[0] = 8'h9F; script[1] = 8'h1B;
        run("R7 other bits", 0, 0, 2, 1, 0);
    endtask

    task automatic t_busy_start(); // R8
        script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h40; script[3] = 8'h00;
        script[4] = 8'h00; script[5] = 8'h00;
        run("R8 busy start", 1, 1, 6, 1, 0);
    endtask

    task automatic t_mid_reset();  // R1
        clear_counts();
        gap_mode = 0;
        script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h00; script[3] = 8'h40;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset rd_req", int'(rd_req), 0);
        repeat (6) @(negedge clk);
        chk("R1 mid reset no pulse", n_done + n_fail, 0);
        chk("R1 stays idle", int'(rd_req), 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) script[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_steady();
        t_repeat();
        t_old_flag();
        t_confirm_ok();
        t_confirm_bad();
        t_other_bits();
        t_busy_start();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule